// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers fifteen interrupt sources, numbered 1 to 15, into a pending register. A per-source mask filters that register. The highest-numbered pending source that is not masked is presented to the processor as a 4-bit interrupt level and an 8-bit trap type. For every source, the source number, its register bit position, its priority level and its trap type are tied together: the trap type is 0x10 plus the source number, so its low nibble equals the level. A level of 0 means that no request is present.

Software reaches the block through a simple register bus with a 3-bit register select. The pending and mask registers can be read. The mask register can be written. Two write-only strobe registers clear or raise pending bits, where a 1 acts and a 0 is ignored. Software raising of pending bits works only while an enable bit in a test-control word is set. The processor retires the request it is serving through an acknowledge input that carries the level being serviced.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the pending register reads 0x0000, the mask register reads 0xFFFE (all sources blocked), the test-control word reads 0, and the level and trap outputs are 0.
- R2: A one-cycle pulse on source input bit i (i from 1 to 15) sets pending bit i at the next clock edge. The bit stays set until it is cleared.
- R3: A bus write with select 2 (clear) removes every pending bit whose data bit is 1 at the next edge. Data bits that are 0 leave their pending bits unchanged.
- R4: When a source pulse, or an effective raise, lands in the same cycle as a clear or acknowledge of the same bit, the pending bit ends up set.
- R5: A bus write with select 3 (raise) sets the pending bits given by its 1 bits, but only while bit 19 of the test-control word (select 4, read/write, 32 bits) is 1. Otherwise the write has no effect.
- R6: The mask register (select 1) is read/write on bits 15..1. A 1 blocks its source and a 0 passes it. Bit 0 always reads 0. Pending is read with select 0, and writes to select 0 are ignored.
- R7: The level output is the highest source number among the bits that are pending and unmasked, or 0 if there are none. It is registered, so it reflects the pending and mask state one clock edge after that state is stored.
- R8: The trap output is 0x10 plus the level when the level is nonzero, and 0x00 when the level is 0. It changes in the same cycle as the level.
- R9: An acknowledge cycle with a nonzero level L clears pending bit L at the next edge. An acknowledge with level 0 has no effect.
- R10: Bit 0 is not a source. A pulse on source bit 0, or a 1 in bit 0 of a raise write, never sets pending bit 0 and never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse_i | input | 16 | One-cycle event pulses, bit i for source i (bit 0 unused) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 3 | Register select: 0 pending, 1 mask, 2 clear, 3 raise, 4 test control |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register (combinational) |
| ack_valid_i | input | 1 | Acknowledge strobe from the processor |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Registered interrupt level, 0 when idle |
| irq_trap_o | output | 8 | Registered trap type matching the level |

## Verification
The two functions that can meet in one cycle are the setting of a pending bit and its removal. A setting comes from a source pulse. A removal comes from either a clear write or an acknowledge. The bench drives a source pulse and a clear write that names the same bit on the same clock edge. It then reads the pending register: the shared bit must still be set, and a second bit named only by the clear must be gone. A per-bit property checks the same precedence on every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int SRC_W     = 16;
    localparam int LVL_W     = $clog2(SRC_W);
    localparam int TRAP_W    = 8;
    localparam int DATA_W    = 32;
    localparam int SEL_W     = 3;
    localparam logic [TRAP_W-1:0] TRAP_BASE = 8'h10;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND  = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_CLR   = 3'd2,
        SEL_RAISE = 3'd3,
        SEL_TEST  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic [LVL_W-1:0]  level;
        logic [TRAP_W-1:0] trap;
    } irq_out_t;

    // Highest set bit among positions 1..SRC_W-1; 0 when none.
    function automatic logic [LVL_W-1:0] top_source(logic [SRC_W-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < SRC_W; i++) begin
            if (v[i]) r = LVL_W'(i);
        end
        return r;
    endfunction

    function automatic logic [TRAP_W-1:0] trap_of(logic [LVL_W-1:0] lvl);
        return (lvl == '0) ? '0 : (TRAP_BASE + TRAP_W'(lvl));
    endfunction

endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
    import prio_irq_pkg::*;
#(
    parameter int TEST_BIT = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    input  reg_sel_e          rd_sel,
    input  logic [SRC_W-1:0]  pend_q,
    output logic [SRC_W-1:0]  mask_q,
    output logic [SRC_W-1:0]  clr_vec,
    output logic [SRC_W-1:0]  raise_vec,
    output logic              test_en,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [SRC_W-1:0] SRC_BITS = {{(SRC_W-1){1'b1}}, 1'b0};

    logic [DATA_W-1:0] test_q;
    logic              wr_mask, wr_clr, wr_raise, wr_test;

    assign wr_mask  = wr.en && (wr.sel == SEL_MASK);
    assign wr_clr   = wr.en && (wr.sel == SEL_CLR);
    assign wr_raise = wr.en && (wr.sel == SEL_RAISE);
    assign wr_test  = wr.en && (wr.sel == SEL_TEST);

    assign test_en  = test_q[TEST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= SRC_BITS;
            test_q <= '0;
        end else begin
            if (wr_mask) mask_q <= wr.data[SRC_W-1:0] & SRC_BITS;
            if (wr_test) test_q <= wr.data;
        end
    end

    always_comb begin
        clr_vec   = wr_clr ? (wr.data[SRC_W-1:0] & SRC_BITS) : '0;
        raise_vec = (wr_raise && test_en) ? (wr.data[SRC_W-1:0] & SRC_BITS) : '0;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_PEND: rdata = DATA_W'(pend_q);
            SEL_MASK: rdata = DATA_W'(mask_q);
            SEL_TEST: rdata = test_q;
            default:  rdata = '0;
        endcase
    end

    assert_mask_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == ($past(wr.data[SRC_W-1:0]) & SRC_BITS)));

    assert_raise_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_raise && !test_en) |-> (raise_vec == '0));

endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_pulse,
    input  logic [SRC_W-1:0] clr_vec,
    input  logic [SRC_W-1:0] raise_vec,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    output logic [SRC_W-1:0] pend_q
);

    assign pend_q[0] = 1'b0;

    for (genvar i = 1; i < SRC_W; i++) begin : g_bit
        logic set_i, kill_i, q_i;

        assign set_i  = src_pulse[i] | raise_vec[i];
        assign kill_i = clr_vec[i] | (ack_valid && (ack_level == LVL_W'(i)));

        always_ff @(posedge clk) begin
            if (rst) q_i <= 1'b0;
            else     q_i <= set_i | (q_i & ~kill_i);
        end

        assign pend_q[i] = q_i;

        assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
            (set_i && kill_i) |=> pend_q[i]);

        assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (rst)
            src_pulse[i] |=> pend_q[i]);

        assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_i) |=> !pend_q[i]);

        assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (pend_q[i] && !kill_i) |=> pend_q[i]);
    end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] pend_q,
    input  logic [SRC_W-1:0] mask_q,
    output irq_out_t         out_q
);

    logic [SRC_W-1:0] req;
    logic [LVL_W-1:0] lvl_d;

    assign req   = pend_q & ~mask_q;
    assign lvl_d = top_source(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.level <= lvl_d;
            out_q.trap  <= trap_of(lvl_d);
        end
    end

    assert_level_pending_R7: assert property (@(posedge clk) disable iff (rst)
        (out_q.level != '0) |-> ((($past(req) >> out_q.level) & SRC_W'(1)) != '0));

    assert_level_highest_R7: assert property (@(posedge clk) disable iff (rst)
        ((($past(req) >> out_q.level) >> 1) == '0));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (out_q.level == '0) |-> (($past(req) & ~SRC_W'(1)) == '0));

    assert_trap_match_R8: assert property (@(posedge clk) disable iff (rst)
        (out_q.level != '0) |-> (out_q.trap[3:0] == out_q.level && out_q.trap[7:4] == 4'h1));

    assert_trap_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (out_q.level == '0) |-> (out_q.trap == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int TEST_BIT = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_pulse_i,
    input  logic              bus_wr_i,
    input  logic [SEL_W-1:0]  bus_sel_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              ack_valid_i,
    input  logic [LVL_W-1:0]  ack_level_i,
    output logic [LVL_W-1:0]  irq_level_o,
    output logic [TRAP_W-1:0] irq_trap_o
);

    bus_wr_t          wr;
    reg_sel_e         sel;
    logic [SRC_W-1:0] pend_q, mask_q, clr_vec, raise_vec;
    logic             test_en;
    irq_out_t         out_q;

    assign sel      = reg_sel_e'(bus_sel_i);
    assign wr.en    = bus_wr_i;
    assign wr.sel   = sel;
    assign wr.data  = bus_wdata_i;

    prio_irq_cfg #(.TEST_BIT(TEST_BIT)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_sel    (sel),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .clr_vec   (clr_vec),
        .raise_vec (raise_vec),
        .test_en   (test_en),
        .rdata     (bus_rdata_o)
    );

    prio_irq_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (src_pulse_i),
        .clr_vec   (clr_vec),
        .raise_vec (raise_vec),
        .ack_valid (ack_valid_i),
        .ack_level (ack_level_i),
        .pend_q    (pend_q)
    );

    prio_irq_arb u_arb (
        .clk    (clk),
        .rst    (rst),
        .pend_q (pend_q),
        .mask_q (mask_q),
        .out_q  (out_q)
    );

    assign irq_level_o = out_q.level;
    assign irq_trap_o  = out_q.trap;

    assert_raise_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && sel == SEL_RAISE && !test_en && src_pulse_i == '0 && !ack_valid_i)
        |=> (pend_q == $past(pend_q)));

    assert_bit0_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ((src_pulse_i & ~SRC_W'(1)) == '0 && !bus_wr_i && !ack_valid_i)
        |=> (pend_q == $past(pend_q)));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_i && ack_level_i != '0 && src_pulse_i[ack_level_i] == 1'b0 && raise_vec[ack_level_i] == 1'b0)
        |=> (pend_q[$past(ack_level_i)] == 1'b0));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] src_pulse;
    logic        bus_wr;
    logic [2:0]  bus_sel;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        ack_valid;
    logic [3:0]  ack_level;
    logic [3:0]  irq_level;
    logic [7:0]  irq_trap;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .src_pulse_i(src_pulse),
        .bus_wr_i(bus_wr), .bus_sel_i(bus_sel), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .ack_valid_i(ack_valid), .ack_level_i(ack_level),
        .irq_level_o(irq_level), .irq_trap_o(irq_trap)
    );

    // {src[15:0], mask[15:0], expected level[3:0]}
    localparam logic [35:0] VECS [6] = '{
        {16'h0012, 16'h0000, 4'd4},
        {16'h8010, 16'h8000, 4'd4},
        {16'hF000, 16'h0000, 4'd15},
        {16'h0002, 16'h0002, 4'd0},
        {16'h0001, 16'h0000, 4'd0},
        {16'h2040, 16'h0000, 4'd13}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(logic [15:0] v);
        @(negedge clk);
        src_pulse = v;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic read_reg(logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic trap_exp(logic [3:0] l, output logic [31:0] t);
        t = (l == 4'd0) ? 32'h0 : (32'h10 + 32'(l));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d, t;
        rst = 1'b1; src_pulse = '0; bus_wr = 1'b0; bus_sel = '0; bus_wdata = '0;
        ack_valid = 1'b0; ack_level = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(3'd0, d); check("R1 pending", d, 32'h0);
        read_reg(3'd1, d); check("R1 mask", d, 32'hFFFE);
        read_reg(3'd4, d); check("R1 test", d, 32'h0);
        check("R1 level", 32'(irq_level), 32'h0);
        check("R1 trap", 32'(irq_trap), 32'h0);

        // R7/R8/R10 table walk
        foreach (VECS[k]) begin
            bus_write(3'd2, 32'hFFFF);
            bus_write(3'd1, 32'(VECS[k][19:4]));
            pulse(VECS[k][35:20]);
            @(negedge clk);
            check($sformatf("R7 vec%0d level", k), 32'(irq_level), 32'(VECS[k][3:0]));
            trap_exp(VECS[k][3:0], t);
            check($sformatf("R8 vec%0d trap", k), 32'(irq_trap), t);
        end
        read_reg(3'd0, d); check("R2 pending after vec", d, 32'h2040);

        // R10 pending bit 0 never set
        bus_write(3'd2, 32'hFFFF);
        pulse(16'h0001);
        read_reg(3'd0, d); check("R10 bit0 pulse", d, 32'h0);

        // R6 mask readback, bit 0 forced to 0, pending writes ignored
        bus_write(3'd1, 32'hFFFF_00FF);
        read_reg(3'd1, d); check("R6 mask read", d, 32'h00FE);
        bus_write(3'd0, 32'hFFFF);
        read_reg(3'd0, d); check("R6 pending write ignored", d, 32'h0);

        // R3 clear with zeros leaving bits
        bus_write(3'd1, 32'h0);
        pulse(16'h0028);
        bus_write(3'd2, 32'h0008);
        read_reg(3'd0, d); check("R3 partial clear", d, 32'h0020);

        // R7 latency of mask change: level 5 stays one cycle after mask write
        @(negedge clk);
        check("R7 level before mask", 32'(irq_level), 32'd5);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 3'd1; bus_wdata = 32'h0020;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 level registered", 32'(irq_level), 32'd5);
        @(negedge clk);
        check("R7 level after mask", 32'(irq_level), 32'd0);
        check("R8 trap idle", 32'(irq_trap), 32'h0);

        // R4 set wins over clear in the same cycle
        bus_write(3'd1, 32'h0);
        bus_write(3'd2, 32'hFFFF);
        pulse(16'h0040);
        @(negedge clk);
        src_pulse = 16'h0020; bus_wr = 1'b1; bus_sel = 3'd2; bus_wdata = 32'h0060;
        @(negedge clk);
        src_pulse = '0; bus_wr = 1'b0;
        read_reg(3'd0, d); check("R4 set beats clear", d, 32'h0020);

        // R5 raise gated by test bit 19
        bus_write(3'd2, 32'hFFFF);
        bus_write(3'd3, 32'h0100);
        read_reg(3'd0, d); check("R5 raise blocked", d, 32'h0);
        bus_write(3'd4, 32'h0008_0000);
        read_reg(3'd4, d); check("R5 test read", d, 32'h0008_0000);
        bus_write(3'd3, 32'h0101);
        read_reg(3'd0, d); check("R5 raise works R10 bit0", d, 32'h0100);
        @(negedge clk);
        check("R8 raised trap", 32'(irq_trap), 32'h18);
        bus_write(3'd4, 32'h0);

        // R9 acknowledge
        bus_write(3'd2, 32'hFFFF);
        pulse(16'h1008);
        @(negedge clk);
        check("R9 level before ack", 32'(irq_level), 32'd12);
        @(negedge clk);
        ack_valid = 1'b1; ack_level = 4'd12;
        @(negedge clk);
        ack_valid = 1'b0; ack_level = 4'd0;
        @(negedge clk);
        check("R9 level after ack", 32'(irq_level), 32'd3);
        check("R9 trap after ack", 32'(irq_trap), 32'h13);
        read_reg(3'd0, d); check("R9 pending after ack", d, 32'h0008);
        @(negedge clk);
        ack_valid = 1'b1; ack_level = 4'd0;
        @(negedge clk);
        ack_valid = 1'b0;
        read_reg(3'd0, d); check("R9 ack level 0 ignored", d, 32'h0008);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule